// File: doc/BRIEF.md
# Atomic Lock and Semaphore Unit

This block is a synchronization engine that sits on the memory side and is shared by several requesters. It keeps a small table of words. Any of these words can serve as a spin lock, a counting semaphore or a shared counter. Each requester drives a valid flag together with an opcode, a table index and an operand. The block services one request per cycle. That request's read-modify-write of its table word completes inside the cycle, so no other requester can observe the word or change it part way through.

A request may be granted in the same cycle it is raised. In the following cycle the block returns a response that carries the requester number, the value the word held before the operation, a success flag and an error flag. Software builds its primitives on these operations. It polls a lock with plain loads and then attempts a test-and-set. It initialises a semaphore to a count. P operations that find the count at zero fail at once, and the requester tries again later.

Top module: `atomic_sync_unit`

## Requirements
- R1: After reset every table word reads 0, no grant is given and no response is valid.
- R2: Opcode 0 (load) returns the word in the old-value field with success 1 and error 0, and leaves the word unchanged.
- R3: Opcode 1 (test-and-set) returns the old word and leaves the word at 1; success is 1 exactly when the old word was 0, and error is 0.
- R4: Opcode 2 (release) returns the old word, writes 0, and reports success 1 and error 0.
- R5: Opcode 3 (fetch-and-add) returns the old word and writes old plus operand modulo 2^W, with success 1 and error 0.
- R6: Opcode 4 (semaphore initialise) returns the old word, writes the operand as the new count, and reports success 1 and error 0.
- R7: Opcode 5 (P) decrements a nonzero word with success 1. On a zero word it changes nothing and reports success 0 and error 0.
- R8: Opcode 6 (V) increments the word with success 1. On a word equal to all ones it changes nothing and reports success 0 and error 1.
- R9: At most one requester is granted per cycle, and only one whose valid is high. The search starts at the requester after the last one granted, and wraps around. After reset requester 0 has the highest priority.
- R10: A response is valid in exactly the cycles that follow a grant. It carries the number of the requester granted in the preceding cycle.
- R11: An operation granted in the cycle right after another operation on the same word sees that earlier operation's result.
- R12: Opcode 7 is reserved. It leaves the word unchanged and reports success 0 and error 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request flag, held until granted |
| req_op | input | 3*NREQ | Per-requester opcode, 3 bits per lane |
| req_idx | input | IW*NREQ | Per-requester table index |
| req_arg | input | W*NREQ | Per-requester operand |
| req_grant | output | NREQ | One-hot grant, same cycle as the accepted request |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDW | Requester number of the response |
| rsp_old | output | W | Word value before the operation |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_err | output | 1 | Saturation or reserved-opcode error |

## Verification
Arbitration and the atomic update coincide when two requesters raise test-and-set or P on the same word in the same cycle. Only one of them may take the word, and the other must see the result of the first. The bench raises both requests together. It predicts the winner from its own record of the last grant, then checks the grant vector in that cycle. It then checks that the loser, served on the next cycle, receives the old value 1 with success 0 from the lock, or a count that has already been decremented from the semaphore.

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit #(
  parameter int NREQ = 4,
  parameter int NENT = 8,
  parameter int W    = 16,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [3*NREQ-1:0] req_op,
  input  logic [IW*NREQ-1:0] req_idx,
  input  logic [W*NREQ-1:0] req_arg,
  output logic [NREQ-1:0]   req_grant,
  output logic              rsp_valid,
  output logic [IDW-1:0]    rsp_id,
  output logic [W-1:0]      rsp_old,
  output logic              rsp_ok,
  output logic              rsp_err
);

  localparam logic [2:0] OP_LOAD = 3'd0;
  localparam logic [2:0] OP_TAS  = 3'd1;
  localparam logic [2:0] OP_REL  = 3'd2;
  localparam logic [2:0] OP_FADD = 3'd3;
  localparam logic [2:0] OP_INIT = 3'd4;
  localparam logic [2:0] OP_P    = 3'd5;
  localparam logic [2:0] OP_V    = 3'd6;
  localparam logic [W-1:0] MAXV  = {W{1'b1}};

  logic [W-1:0]   tbl [NENT];
  logic [IDW-1:0] last_gnt;
  logic [IDW-1:0] sel;
  logic           hit;

  always_comb begin
    int c;
    sel = '0;
    hit = 1'b0;
    c = 0;
    for (int k = 1; k <= NREQ; k++) begin
      c = (int'(last_gnt) + k) % NREQ;
      if (!hit && req_valid[c]) begin
        hit = 1'b1;
        sel = IDW'(c);
      end
    end
  end

  assign req_grant = hit ? (NREQ'(1) << sel) : '0;

  logic [2:0]   s_op;
  logic [IW-1:0] s_idx;
  logic [W-1:0] s_arg;
  logic [W-1:0] cur;

  assign s_op  = req_op[sel*3 +: 3];
  assign s_idx = req_idx[sel*IW +: IW];
  assign s_arg = req_arg[sel*W +: W];
  assign cur   = tbl[s_idx];

  logic [W-1:0] nxt;
  logic         wr, ok, err;

  always_comb begin
    nxt = cur;
    wr  = 1'b0;
    ok  = 1'b1;
    err = 1'b0;
    case (s_op)
      OP_LOAD: ;
      OP_TAS: begin
        nxt = W'(1);
        wr  = 1'b1;
        ok  = (cur == '0);
      end
      OP_REL: begin
        nxt = '0;
        wr  = 1'b1;
      end
      OP_FADD: begin
        nxt = cur + s_arg;
        wr  = 1'b1;
      end
      OP_INIT: begin
        nxt = s_arg;
        wr  = 1'b1;
      end
      OP_P: begin
        if (cur != '0) begin
          nxt = cur - W'(1);
          wr  = 1'b1;
        end else begin
          ok = 1'b0;
        end
      end
      OP_V: begin
        if (cur != MAXV) begin
          nxt = cur + W'(1);
          wr  = 1'b1;
        end else begin
          ok  = 1'b0;
          err = 1'b1;
        end
      end
      default: begin
        ok  = 1'b0;
        err = 1'b1;
      end
    endcase
  end

  logic [IW-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
      last_gnt  <= IDW'(NREQ - 1);
      last_idx  <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_old   <= '0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= hit;
      if (hit) begin
        if (wr) tbl[s_idx] <= nxt;
        last_gnt <= sel;
        last_idx <= s_idx;
        rsp_id   <= sel;
        rsp_old  <= cur;
        rsp_ok   <= ok;
        rsp_err  <= err;
      end
    end
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));

  p_grant_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |=> rsp_valid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> !rsp_valid);

  p_tas_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && s_op == OP_TAS) |=> (tbl[last_idx] == W'(1)));

  p_load_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && s_op == OP_LOAD) |=> (tbl[last_idx] == rsp_old));

  p_p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && s_op == OP_P && cur == '0) |=> (!rsp_ok && !rsp_err && tbl[last_idx] == '0));

  p_v_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && s_op == OP_V && cur == MAXV) |=> (rsp_err && tbl[last_idx] == MAXV));

endmodule

// File: tb/atomic_sync_unit_bench.sv
module atomic_sync_unit_bench;
  localparam int NREQ = 4, NENT = 8, W = 16, IW = 3, IDW = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [NREQ-1:0]    req_valid = '0;
  logic [3*NREQ-1:0]  req_op = '0;
  logic [IW*NREQ-1:0] req_idx = '0;
  logic [W*NREQ-1:0]  req_arg = '0;
  logic [NREQ-1:0]    req_grant;
  logic               rsp_valid, rsp_ok, rsp_err;
  logic [IDW-1:0]     rsp_id;
  logic [W-1:0]       rsp_old;

  atomic_sync_unit #(.NREQ(NREQ), .NENT(NENT), .W(W)) u_atomic_sync_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_arg(req_arg), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_old(rsp_old),
    .rsp_ok(rsp_ok), .rsp_err(rsp_err));

  typedef struct {
    int unsigned id;
    logic [W-1:0] old;
    logic ok;
    logic err;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [W-1:0] mdl [NENT];
  int lp = NREQ - 1;
  bit done = 0;

  function automatic exp_t predict(int id, logic [2:0] op, int idx, logic [W-1:0] arg, string tag);
    exp_t e;
    logic [W-1:0] v;
    v = mdl[idx];
    e.id = id; e.old = v; e.ok = 1; e.err = 0; e.tag = tag;
    case (op)
      3'd0: ;
      3'd1: begin e.ok = (v == 0); mdl[idx] = 1; end
      3'd2: mdl[idx] = 0;
      3'd3: mdl[idx] = v + arg;
      3'd4: mdl[idx] = arg;
      3'd5: if (v != 0) mdl[idx] = v - 1; else e.ok = 0;
      3'd6: if (v != '1) mdl[idx] = v + 1; else begin e.ok = 0; e.err = 1; end
      default: begin e.ok = 0; e.err = 1; end
    endcase
    return e;
  endfunction

  task automatic lane(int id, logic [2:0] op, int idx, logic [W-1:0] arg);
    req_op[id*3 +: 3] = op;
    req_idx[id*IW +: IW] = IW'(idx);
    req_arg[id*W +: W] = arg;
    req_valid[id] = 1'b1;
  endtask

  task automatic check_grant(int id, string tag);
    checks++;
    if (req_grant !== (NREQ'(1) << id)) begin
      fails++;
      $display("FAIL %s grant: actual %b expected %b", tag, req_grant, NREQ'(1) << id);
    end
  endtask

  task automatic issue(int id, logic [2:0] op, int idx, logic [W-1:0] arg, string tag);
    @(negedge clk);
    lane(id, op, idx, arg);
    #1;
    check_grant(id, tag);
    q.push_back(predict(id, op, idx, arg, tag));
    lp = id;
    @(posedge clk); #1;
    req_valid[id] = 1'b0;
  endtask

  task automatic pair(int a, logic [2:0] opa, int ia, logic [W-1:0] aa,
                      int b, logic [2:0] opb, int ib, logic [W-1:0] ab, string tag);
    int w, l;
    @(negedge clk);
    lane(a, opa, ia, aa);
    lane(b, opb, ib, ab);
    #1;
    w = -1;
    for (int k = 1; k <= NREQ; k++)
      if (w < 0 && (((lp + k) % NREQ) == a || ((lp + k) % NREQ) == b)) w = (lp + k) % NREQ;
    l = (w == a) ? b : a;
    check_grant(w, tag);
    if (w == a) q.push_back(predict(a, opa, ia, aa, tag));
    else        q.push_back(predict(b, opb, ib, ab, tag));
    lp = w;
    @(posedge clk); #1;
    req_valid[w] = 1'b0;
    @(negedge clk); #1;
    check_grant(l, tag);
    if (l == a) q.push_back(predict(a, opa, ia, aa, tag));
    else        q.push_back(predict(b, opb, ib, ab, tag));
    lp = l;
    @(posedge clk); #1;
    req_valid[l] = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected response: actual id %0d expected none", rsp_id);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_id !== IDW'(e.id) || rsp_old !== e.old || rsp_ok !== e.ok || rsp_err !== e.err) begin
          fails++;
          $display("FAIL %s/R10 response: actual id %0d old %h ok %b err %b expected id %0d old %h ok %b err %b",
                   e.tag, rsp_id, rsp_old, rsp_ok, rsp_err, e.id, e.old, e.ok, e.err);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_grant !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual valid %b grant %b expected 0 0", rsp_valid, req_grant);
    end
    rst_n = 1;
    // R1: all words read zero; requester 0 first priority (R9)
    for (int i = 0; i < NENT; i++) issue(i % NREQ, 3'd0, i, '0, "R1");
    // R6 / R2
    issue(1, 3'd4, 2, 16'd5, "R6");
    issue(2, 3'd0, 2, '0, "R2");
    issue(3, 3'd0, 2, '0, "R2");
    // R3
    issue(0, 3'd1, 0, '0, "R3");
    issue(1, 3'd1, 0, '0, "R3");
    issue(2, 3'd0, 0, '0, "R3");
    // R4
    issue(3, 3'd2, 0, '0, "R4");
    issue(0, 3'd0, 0, '0, "R4");
    // R5 with wrap
    issue(1, 3'd3, 3, 16'h0010, "R5");
    issue(2, 3'd3, 3, 16'hFFF5, "R5");
    issue(3, 3'd0, 3, '0, "R5");
    // R7
    issue(0, 3'd4, 4, 16'd1, "R7");
    issue(1, 3'd5, 4, '0, "R7");
    issue(2, 3'd5, 4, '0, "R7");
    issue(3, 3'd6, 4, '0, "R7");
    issue(0, 3'd0, 4, '0, "R7");
    // R8 saturation
    issue(1, 3'd4, 5, 16'hFFFE, "R8");
    issue(2, 3'd6, 5, '0, "R8");
    issue(3, 3'd6, 5, '0, "R8");
    issue(0, 3'd0, 5, '0, "R8");
    // R12 reserved opcode
    issue(1, 3'd7, 5, 16'h1234, "R12");
    issue(2, 3'd0, 5, '0, "R12");
    // R11 back-to-back on one word
    issue(3, 3'd3, 6, 16'd7, "R11");
    issue(0, 3'd3, 6, 16'd1, "R11");
    issue(1, 3'd0, 6, '0, "R11");
    // R9 contention on the same lock and semaphore
    pair(1, 3'd1, 7, '0, 3, 3'd1, 7, '0, "R9");
    pair(0, 3'd5, 4, '0, 2, 3'd5, 4, '0, "R9");
    pair(2, 3'd2, 7, '0, 0, 3'd1, 7, '0, "R9");
    // R10 idle cycles: no response expected
    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule